// File: doc/BRIEF.md
# Block-Parallel Zero-Terminator Length Finder

This block measures a byte string that ends with a zero byte. It does not walk the string one byte at a time. Each cycle it reads one naturally aligned block of `BLK_BYTES` bytes from a synchronous memory port and tests every byte of that block against zero at the same moment. The per-byte results form a lane mask. The lowest set bit of that mask marks the terminator.

The block uses aligned fetches only, so a read never straddles a power-of-two boundary, even when it runs past the end of the string. On the first block, the block disregards any lane that lies below the start address. When a block holds no zero byte, the next block's read is issued in the same cycle, which keeps a throughput of one block per cycle. When the terminator is found, the block pulses `done` and presents the byte count, not counting the terminator. The count stays on the port until the next result.

Top module: `strscan_top`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `mem_req` are 0 and `length` is 0.
- R2: A `start` accepted while idle causes a memory read in the following cycle at `start_addr` rounded down to a multiple of `BLK_BYTES` (16 by default).
- R3: Every `mem_addr` presented with `mem_req` is a multiple of `BLK_BYTES`. Back-to-back reads advance by exactly `BLK_BYTES`. Byte lane i of `mem_rdata` (bits 8i+7..8i) holds the byte at block address + i, and the data arrives in the cycle after the request.
- R4: In the first block, zero bytes that sit at addresses below `start_addr` do not count as terminators.
- R5: When a block holds several zero bytes, the lowest-addressed one at or above the start determines `length`. Bytes after it are ignored.
- R6: When the byte at `start_addr` is itself zero, `length` is 0.
- R7: A block without a terminator is followed by a read of the next block. The number of reads equals the number of blocks from the start's block through the terminator's block, and `length` counts the bytes across all of them.
- R8: `done` is high for exactly one cycle per scan. `length` changes only in that cycle and holds its value until the next `done`.
- R9: A `start` raised while `busy` is 1 is ignored and does not change the scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (honoured only while idle) |
| start_addr | input | 32 | Byte address of the first character |
| busy | output | 1 | A scan is in progress |
| mem_req | output | 1 | Block read request |
| mem_addr | output | 32 | Aligned block byte address |
| mem_rdata | input | 8*BLK_BYTES | Block data, valid the cycle after `mem_req` |
| done | output | 1 | One-cycle result strobe |
| length | output | 32 | Bytes before the terminator |

## Verification
A corrupted start offset or first-block flag would show up as a wrong `length` on the same `done` pulse. This happens when a zero sits just before the start address or when the start byte is zero. A wrong block pointer would show up in the cycle it occurs, as a misaligned `mem_addr` or a skipped stride on the read port. It would also appear at `done` as a read count that differs from the number of blocks spanned. A state machine left stuck out of idle would show as `busy` remaining high and no `done` pulse arriving.

// File: rtl/strscan_pkg.sv
package strscan_pkg;

    localparam int ADDR_W        = 32;
    localparam int DEF_BLK_BYTES = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SCAN  = 2'd2
    } scan_state_e;

    typedef struct packed {
        addr_t base;   // original start address
        addr_t blk;    // address of block being examined
        logic  first;  // block is the one containing base
    } scan_ctx_t;

    function automatic addr_t align_down(addr_t a, int unsigned blk_bytes);
        addr_t m;
        m = addr_t'(blk_bytes) - addr_t'(1);
        return a & ~m;
    endfunction

endpackage

// File: rtl/strscan_zmask.sv
module strscan_zmask #(
    parameter int BLK_BYTES = strscan_pkg::DEF_BLK_BYTES,
    localparam int OFF_W    = $clog2(BLK_BYTES)
) (
    input  logic [8*BLK_BYTES-1:0] data,
    input  logic [OFF_W-1:0]       lo_off,
    input  logic                   apply_off,
    output logic [BLK_BYTES-1:0]   mask
);
    // One comparator per lane; lanes under the start offset are suppressed.
    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
        logic is_zero;
        logic in_range;
        assign is_zero  = (data[8*g +: 8] == 8'h00);
        assign in_range = !apply_off || (OFF_W'(g) >= lo_off);
        assign mask[g]  = is_zero && in_range;
    end
endmodule

// File: rtl/strscan_ffs.sv
module strscan_ffs #(
    parameter int N     = strscan_pkg::DEF_BLK_BYTES,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest set bit wins: scan from the top so lower lanes overwrite.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/strscan_ctrl.sv
module strscan_ctrl
    import strscan_pkg::*;
#(
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    localparam int OFF_W    = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  addr_t            start_addr,
    input  logic             hit,
    input  logic [OFF_W-1:0] hit_idx,
    output logic             busy,
    output logic             mem_req,
    output addr_t            mem_addr,
    output logic [OFF_W-1:0] lo_off,
    output logic             apply_off,
    output logic             done,
    output addr_t            length
);
    localparam addr_t STEP = addr_t'(BLK_BYTES);

    scan_state_e state;
    scan_ctx_t   ctx;
    addr_t       next_blk;

    assign next_blk  = ctx.blk + STEP;
    assign busy      = (state != ST_IDLE);
    assign lo_off    = ctx.base[OFF_W-1:0];
    assign apply_off = ctx.first;

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = ctx.blk;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ctx.blk;
            end
            ST_SCAN: begin
                if (!hit) begin
                    mem_req  = 1'b1;
                    mem_addr = next_blk;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctx    <= '0;
            done   <= 1'b0;
            length <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctx.base  <= start_addr;
                        ctx.blk   <= align_down(start_addr, BLK_BYTES);
                        ctx.first <= 1'b1;
                        state     <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_SCAN;
                ST_SCAN: begin
                    if (hit) begin
                        done   <= 1'b1;
                        length <= ctx.blk + addr_t'(hit_idx) - ctx.base;
                        state  <= ST_IDLE;
                    end else begin
                        ctx.blk   <= next_blk;
                        ctx.first <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/strscan_top.sv
module strscan_top
    import strscan_pkg::*;
#(
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int DATA_W   = 8 * BLK_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] length
);
    logic [BLK_BYTES-1:0] zmask;
    logic [OFF_W-1:0]     lo_off;
    logic                 apply_off;
    logic                 hit;
    logic [OFF_W-1:0]     hit_idx;

    strscan_zmask #(.BLK_BYTES(BLK_BYTES)) u_zmask (
        .data      (mem_rdata),
        .lo_off    (lo_off),
        .apply_off (apply_off),
        .mask      (zmask)
    );

    strscan_ffs #(.N(BLK_BYTES)) u_ffs (
        .vec   (zmask),
        .found (hit),
        .idx   (hit_idx)
    );

    strscan_ctrl #(.BLK_BYTES(BLK_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .lo_off     (lo_off),
        .apply_off  (apply_off),
        .done       (done),
        .length     (length)
    );
endmodule

// File: rtl/strscan_chk.sv
module strscan_chk
    import strscan_pkg::*;
#(
    parameter int BLK_BYTES = DEF_BLK_BYTES
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input addr_t       start_addr,
    input logic        busy,
    input logic        mem_req,
    input addr_t       mem_addr,
    input logic        done,
    input addr_t       length
);
    localparam addr_t LOWM = addr_t'(BLK_BYTES) - addr_t'(1);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req && length == '0));

    a_r2_first_fetch: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (mem_req && mem_addr == ($past(start_addr) & ~LOWM)));

    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_addr & LOWM) == '0));

    a_r3_stride: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + addr_t'(BLK_BYTES)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_len_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(length) |-> done);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));
endmodule

bind strscan_top strscan_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (done),
    .length     (length)
);

// File: tb/sim_strscan_top.sv
module sim_strscan_top;
    localparam int BLK   = 16;
    localparam int MEMSZ = 512;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  start_addr = '0;
    logic         busy, mem_req, done;
    logic [31:0]  mem_addr, length;
    logic [127:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;

    byte unsigned mem [MEMSZ];

    typedef struct {
        logic [31:0] len;
        int          nfetch;
        string       tag;
    } exp_t;
    exp_t q[$];

    int nfetch   = 0;
    int jobs_out = 0;
    logic        prev_req = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        chk_pulse = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    strscan_top u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .length(length)
    );

    // memory model: one cycle read latency, lane i = byte at addr+i
    always @(posedge clk) begin
        if (mem_req) begin
            for (int i = 0; i < BLK; i++)
                mem_rdata[8*i +: 8] <= mem[(mem_addr + i) % MEMSZ];
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: fetch stream and results
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_pulse) begin
                check(done == 1'b0, "R8 done pulse width", 32'(done), 32'd0);
                chk_pulse = 1'b0;
            end
            if (mem_req) begin
                nfetch++;
                check(mem_addr[3:0] == 4'd0, "R3 aligned fetch", mem_addr, mem_addr & ~32'hF);
                if (prev_req)
                    check(mem_addr == prev_addr + BLK, "R3 stride", mem_addr, prev_addr + BLK);
            end
            prev_req  = mem_req;
            prev_addr = mem_addr;
            if (done) begin
                exp_t e;
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    check(length == e.len, e.tag, length, e.len);
                    check(nfetch == e.nfetch, {e.tag, " R7 fetch count"}, 32'(nfetch), 32'(e.nfetch));
                end
                nfetch    = 0;
                chk_pulse = 1'b1;
                jobs_out++;
            end
        end
    end

    task automatic run_job(logic [31:0] a, logic [31:0] exp_len, int exp_f, string tag,
                           bit poke_busy = 1'b0);
        exp_t e;
        int target;
        e.len = exp_len; e.nfetch = exp_f; e.tag = tag;
        q.push_back(e);
        target = jobs_out + 1;
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
        check(mem_req && mem_addr == (a & ~32'hF), "R2 first fetch", mem_addr, a & ~32'hF);
        if (poke_busy) begin
            @(negedge clk);
            check(busy == 1'b1, "R9 busy during scan", 32'(busy), 32'd1);
            start = 1'b1; start_addr = 32'h20;
            @(negedge clk);
            start = 1'b0;
        end
        while (jobs_out < target) @(negedge clk);
        @(negedge clk); @(negedge clk);
        check(length == exp_len, "R8 length held", length, exp_len);
        check(busy == 1'b0, "R9 idle after scan", 32'(busy), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h30 | byte'(i & 15) | 8'h40;
        mem['h25]  = 0;                  // job 1
        mem['h41]  = 0; mem['h48] = 0;   // job 2 (R4)
        mem['h60]  = 0;                  // job 3 (R6)
        mem['h8A]  = 0; mem['h8C] = 0;   // job 4 (R5)
        mem['hD3]  = 0;                  // job 5 (R7)
        mem['h112] = 0;                  // job 6
        mem['h17E] = 0;                  // job 7 (R9)
        mem['h1FF] = 0;                  // job 8

        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && length == 0, "R1 reset state", length, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req && length == 0, "R1 after reset", 32'(busy), 32'd0);

        run_job(32'h20,  32'd5,  1, "R5 basic");
        run_job(32'h43,  32'd5,  1, "R4 zero below start ignored");
        run_job(32'h60,  32'd0,  1, "R6 empty string");
        run_job(32'h85,  32'd5,  1, "R5 lowest zero wins");
        run_job(32'hA7,  32'd44, 4, "R7 multi-block");
        run_job(32'h10F, 32'd3,  2, "R7 last-lane start");
        run_job(32'h140, 32'd62, 4, "R9 start while busy ignored", 1'b1);
        run_job(32'h1F0, 32'd15, 1, "R5 terminator in top lane");

        @(negedge clk);
        check(q.size() == 0, "R8 all results seen", 32'(q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule